// File: doc/BRIEF.md
# Serial Programming Port for a Dual-Loop Frequency Synthesizer

This block receives configuration words over a three-line serial port (serial clock, serial data, load strobe) and holds them for the two phase-locked loops of a synthesizer. Bits are taken on each rising edge of the serial clock, most significant first, into a word register. The last two bits of a word are a route code; a rising edge on the load line copies the other bits into one of four holding latches: a reference word and a feedback word for each of the two loops.

The latched words are split into fields for the neighbouring blocks: the reference divide ratio and five mode bits (detector polarity, pump current, pump tristate, lock-detect select, status-output select) from each reference word; the swallow count, the main count, the prescaler choice and the powerdown bit from each feedback word. All three serial lines are synchronized into the system clock domain, where their edges are found. A one-cycle pulse tells downstream logic which latch was just written.

Loop vectors are indexed by the low route bit: index 1 is loop 1, index 0 is loop 2.

Top module: `synth_prog_port`

## Requirements
- R1: After reset every latch holds zero, so every field output and `wr_strobe_o` read zero.
- R2: Each rising edge of `ser_clk_i` shifts the synchronized `ser_dat_i` into the word register, first bit ending up most significant; falling edges shift nothing.
- R3: A rising edge of `ser_le_i` writes the 20 bits above the route code into the latch named by the two final bits {C1,C2}: 00 loop 2 reference, 01 loop 1 reference, 10 loop 2 feedback, 11 loop 1 feedback. The other three latches keep their contents.
- R4: In a reference word (data bit 1 = first bit after the route code, counting upward toward the first bit sent), bits 1..15 are the divide ratio with bit 1 as LSB; bit 16 drives `pd_pos_o`, 17 `pump_hi_o`, 18 `pump_tri_o`, 19 `lock_sel_o`, 20 `fo_sel_o`.
- R5: In a feedback word, bits 1..7 are the swallow count (bit 1 LSB), bits 8..18 the main count (bit 8 LSB), bit 19 drives `presc_hi_o` (1 = the larger modulus pair) and bit 20 drives `pwdn_o`.
- R6: Field outputs change only on a load strobe; shifting any number of bits without a load leaves them unchanged.
- R7: Each load produces exactly one single-cycle pulse on `wr_strobe_o`, bit index {C1,C2}, in the cycle the latch takes the new word.
- R8: When more than 22 bits are shifted before a load, only the last 22 count.
- R9: Words keep loading and routing normally while either loop has its powerdown bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous) |
| ref_div_o | output | 30 | Reference divide ratio per loop, 15 bits each |
| pd_pos_o | output | 2 | Phase detector polarity, 1 = positive |
| pump_hi_o | output | 2 | Pump current select, 1 = high |
| pump_tri_o | output | 2 | Pump output tristate request |
| lock_sel_o | output | 2 | Lock-detect select bit for the status output |
| fo_sel_o | output | 2 | Divider-monitor select bit for the status output |
| swal_o | output | 14 | Swallow count per loop, 7 bits each |
| prog_o | output | 22 | Main count per loop, 11 bits each |
| presc_hi_o | output | 2 | Prescaler modulus choice, 1 = larger pair |
| pwdn_o | output | 2 | Powerdown request per loop |
| wr_strobe_o | output | 4 | One-cycle write pulse, bit index = route code |

## Verification
The bench builds the port with three synchronizer stages rather than the default two, keeping the default field widths of a 15-bit reference ratio, 7-bit swallow count and 11-bit main count, so the full 22-bit word and all four routes are in play. The deeper synchronizer lengthens the pin-to-strobe latency, which exercises the claim that results depend only on edge order, not on a fixed cycle count. All-ones and alternating field patterns reach every field boundary, and overlong bursts and bit runs without a load reach the hold and truncation rules.

// File: rtl/pllprog_pkg.sv
package pllprog_pkg;
   localparam int unsigned NUM_LOOPS   = 2;
   localparam int unsigned NUM_LATCH   = 2 * NUM_LOOPS;
   localparam int unsigned ROUTE_W     = 2;
   localparam int unsigned REF_MODE_W  = 5;
   localparam int unsigned FB_MODE_W   = 2;

   typedef enum logic [ROUTE_W-1:0] {
      RT_L2_REF = 2'b00,
      RT_L1_REF = 2'b01,
      RT_L2_FB  = 2'b10,
      RT_L1_FB  = 2'b11
   } route_e;
endpackage

// File: rtl/pp_line_sync.sv
module pp_line_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RISE   = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pp_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   if (RISE) begin : g_rise
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q <= 1'b0;
         else         prev_q <= chain_q[STAGES-1];
      end
      assign q_o = chain_q[STAGES-1] & ~prev_q;

      a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
         q_o |=> !q_o);
   end else begin : g_level
      assign q_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/pp_shifter.sv
module pp_shifter #(
   parameter int unsigned WORD_W = 22
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W < 3) begin : g_bad_width
      $error("pp_shifter: WORD_W too small");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_o <= '0;
      else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
   end

   a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> word_o == {$past(word_o[WORD_W-2:0]), $past(bit_i)});

   a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(word_o));
endmodule

// File: rtl/pp_latch_bank.sv
module pp_latch_bank
   import pllprog_pkg::*;
#(
   parameter int unsigned WORD_W = 22,
   localparam int unsigned DATA_W = WORD_W - ROUTE_W
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic                               load_i,
   input  logic [WORD_W-1:0]                  word_i,
   output logic [NUM_LATCH-1:0][DATA_W-1:0]   lat_o,
   output logic [NUM_LATCH-1:0]               strobe_o
);
   route_e            route;
   logic [DATA_W-1:0] payload;

   assign route   = route_e'(word_i[ROUTE_W-1:0]);
   assign payload = word_i[WORD_W-1:ROUTE_W];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lat_o    <= '0;
         strobe_o <= '0;
      end else begin
         strobe_o <= load_i ? (NUM_LATCH'(1) << route) : '0;
         if (load_i) lat_o[route] <= payload;
      end
   end

   a_r7_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(strobe_o));

   a_r7_strobe_per_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> $countones(strobe_o) == 1);

   a_r6_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(lat_o));

   for (genvar g = 0; g < NUM_LATCH; g++) begin : g_route_chk
      a_r3_other_latch_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (load_i && route != route_e'(g)) |=> $stable(lat_o[g]));
      a_r3_target_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (load_i && route == route_e'(g)) |=> lat_o[g] == $past(payload));
   end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
   import pllprog_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REF_W       = 15,
   parameter int unsigned SWAL_W      = 7,
   parameter int unsigned PROG_W      = 11
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          ser_clk_i,
   input  logic                          ser_dat_i,
   input  logic                          ser_le_i,
   output logic [NUM_LOOPS*REF_W-1:0]    ref_div_o,
   output logic [NUM_LOOPS-1:0]          pd_pos_o,
   output logic [NUM_LOOPS-1:0]          pump_hi_o,
   output logic [NUM_LOOPS-1:0]          pump_tri_o,
   output logic [NUM_LOOPS-1:0]          lock_sel_o,
   output logic [NUM_LOOPS-1:0]          fo_sel_o,
   output logic [NUM_LOOPS*SWAL_W-1:0]   swal_o,
   output logic [NUM_LOOPS*PROG_W-1:0]   prog_o,
   output logic [NUM_LOOPS-1:0]          presc_hi_o,
   output logic [NUM_LOOPS-1:0]          pwdn_o,
   output logic [NUM_LATCH-1:0]          wr_strobe_o
);
   localparam int unsigned DATA_W = REF_W + REF_MODE_W;
   localparam int unsigned WORD_W = DATA_W + ROUTE_W;

   if (SWAL_W + PROG_W + FB_MODE_W != DATA_W) begin : g_bad_split
      $error("synth_prog_port: feedback fields do not fill the data word");
   end

   logic sck_rise, dat_lvl, le_rise;
   logic [WORD_W-1:0] word;
   logic [NUM_LATCH-1:0][DATA_W-1:0] lat;

   pp_line_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) i_sync_sck (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_clk_i), .q_o(sck_rise));
   pp_line_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0)) i_sync_dat (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_dat_i), .q_o(dat_lvl));
   pp_line_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1)) i_sync_le (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ser_le_i), .q_o(le_rise));

   pp_shifter #(.WORD_W(WORD_W)) i_shift (
      .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sck_rise), .bit_i(dat_lvl), .word_o(word));

   pp_latch_bank #(.WORD_W(WORD_W)) i_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(le_rise), .word_i(word),
      .lat_o(lat), .strobe_o(wr_strobe_o));

   for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_loop
      logic [DATA_W-1:0] refw, fbw;
      assign refw = lat[l];
      assign fbw  = lat[NUM_LOOPS + l];

      assign ref_div_o[l*REF_W +: REF_W]   = refw[REF_W-1:0];
      assign pd_pos_o[l]                   = refw[REF_W];
      assign pump_hi_o[l]                  = refw[REF_W+1];
      assign pump_tri_o[l]                 = refw[REF_W+2];
      assign lock_sel_o[l]                 = refw[REF_W+3];
      assign fo_sel_o[l]                   = refw[REF_W+4];

      assign swal_o[l*SWAL_W +: SWAL_W]    = fbw[SWAL_W-1:0];
      assign prog_o[l*PROG_W +: PROG_W]    = fbw[SWAL_W +: PROG_W];
      assign presc_hi_o[l]                 = fbw[SWAL_W+PROG_W];
      assign pwdn_o[l]                     = fbw[SWAL_W+PROG_W+1];
   end

   a_r9_load_in_powerdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (le_rise && pwdn_o != '0) |=> wr_strobe_o != '0);

   a_r6_fields_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_strobe_o == '0) |-> ($stable(ref_div_o) && $stable(swal_o) && $stable(prog_o)
                               && $stable(pwdn_o) && $stable(presc_hi_o)));
endmodule

// File: tb/test_synth_prog_port.sv
module test_synth_prog_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;

   logic [29:0] ref_div;
   logic [1:0]  pd_pos, pump_hi, pump_tri, lock_sel, fo_sel, presc_hi, pwdn;
   logic [13:0] swal;
   logic [21:0] prog;
   logic [3:0]  wr_strobe;

   int n_chk = 0, n_fail = 0;

   typedef struct packed { logic [1:0] route; logic [19:0] data; } exp_t;
   exp_t        exp_q[$];
   logic [19:0] model [4];

   always #4 clk = ~clk;

   synth_prog_port #(.SYNC_STAGES(3)) i_synth_prog_port (
      .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_le_i(ser_le),
      .ref_div_o(ref_div), .pd_pos_o(pd_pos), .pump_hi_o(pump_hi), .pump_tri_o(pump_tri),
      .lock_sel_o(lock_sel), .fo_sel_o(fo_sel), .swal_o(swal), .prog_o(prog),
      .presc_hi_o(presc_hi), .pwdn_o(pwdn), .wr_strobe_o(wr_strobe));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected fields derived from the requirement bit positions
   task automatic check_fields(input string ctx);
      for (int l = 0; l < 2; l++) begin
         logic [19:0] rw, fw;
         rw = model[l];
         fw = model[2 + l];
         check($sformatf("R4 %s ref_div[%0d]", ctx, l), 32'(ref_div[l*15 +: 15]), 32'(rw[14:0]));
         check($sformatf("R4 %s pd_pos[%0d]", ctx, l), 32'(pd_pos[l]), 32'(rw[15]));
         check($sformatf("R4 %s pump_hi[%0d]", ctx, l), 32'(pump_hi[l]), 32'(rw[16]));
         check($sformatf("R4 %s pump_tri[%0d]", ctx, l), 32'(pump_tri[l]), 32'(rw[17]));
         check($sformatf("R4 %s lock_sel[%0d]", ctx, l), 32'(lock_sel[l]), 32'(rw[18]));
         check($sformatf("R4 %s fo_sel[%0d]", ctx, l), 32'(fo_sel[l]), 32'(rw[19]));
         check($sformatf("R5 %s swal[%0d]", ctx, l), 32'(swal[l*7 +: 7]), 32'(fw[6:0]));
         check($sformatf("R5 %s prog[%0d]", ctx, l), 32'(prog[l*11 +: 11]), 32'(fw[17:7]));
         check($sformatf("R5 %s presc_hi[%0d]", ctx, l), 32'(presc_hi[l]), 32'(fw[18]));
         check($sformatf("R5 %s pwdn[%0d]", ctx, l), 32'(pwdn[l]), 32'(fw[19]));
      end
   endtask

   task automatic put_bit(input logic b);
      ser_dat = b;
      repeat (2) @(posedge clk);
      #1 ser_clk = 1'b1;
      repeat (5) @(posedge clk);
      #1 ser_clk = 1'b0;
      repeat (5) @(posedge clk);
      #1;
   endtask

   task automatic pulse_load();
      ser_le = 1'b1;
      repeat (8) @(posedge clk);
      #1 ser_le = 1'b0;
      repeat (8) @(posedge clk);
      #1;
   endtask

   // driver: shift a full word MSB first, load it, queue the expected write
   task automatic send_word(input logic [1:0] route, input logic [19:0] data);
      logic [21:0] w;
      w = {data, route};
      for (int i = 21; i >= 0; i--) put_bit(w[i]);
      exp_q.push_back('{route: route, data: data});
      pulse_load();
   endtask

   // monitor: compares every write pulse against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && wr_strobe != 4'b0) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R7 unexpected strobe actual=%0h expected=0", wr_strobe);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R7 strobe index", 32'(wr_strobe), 32'(4'b0001 << e.route));
               model[e.route] = e.data;
               check_fields($sformatf("R3 after route %0d", e.route));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = '0;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      check_fields("R1 reset");
      check("R1 strobe idle", 32'(wr_strobe), 32'h0);

      // R3/R4/R5/R7: one word to each latch, distinct patterns
      send_word(2'b01, {5'b10110, 15'h4A5C});
      send_word(2'b00, {5'b01001, 15'h0003});
      send_word(2'b11, {1'b0, 1'b1, 11'h5A3, 7'h2B});
      send_word(2'b10, {1'b0, 1'b0, 11'h003, 7'h7F});

      // R6: bits shifted with no load leave outputs alone; R2 falling edges inert
      for (int i = 0; i < 22; i++) put_bit(i[0]);
      check_fields("R6 no load");

      // R2/R8: extra leading bits are pushed out, last 22 count
      for (int i = 0; i < 5; i++) put_bit(1'b1);
      send_word(2'b00, 20'hFFFFF);
      send_word(2'b11, 20'hAAAAA);

      // R9: both loops powered down, loads continue
      send_word(2'b10, {1'b1, 1'b1, 11'h7FF, 7'h00});
      send_word(2'b11, {1'b1, 1'b0, 11'h400, 7'h40});
      send_word(2'b01, {5'b00000, 15'h7FFF});
      check("R9 pwdn both", 32'(pwdn), 32'h3);
      send_word(2'b10, {1'b0, 1'b1, 11'h155, 7'h55});

      repeat (20) @(posedge clk);
      #1;
      check("R7 all loads pulsed", 32'(exp_q.size()), 32'h0);
      check_fields("R6 final");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule